// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a processor's 16-bit virtual address and two physical paths: a legacy peripheral bus with 18 address bits and a fast memory path with 21 address bits. Each access carries a processor mode and an instruction/data flag. These two values select one slot of an eight-slot space descriptor table. The slot names one of four 64-entry page tables and gives a per-space page limit and a transparent flag. The page table entry then supplies the physical page, the access permissions and the bus target.

An access is presented for one cycle with its valid strobe. One clock later the block presents:
- the translated address;
- a strobe for the chosen bus;
- an abort request with a cause code, in which case neither strobe fires.

On every successful mapped access the hardware sets the accessed bit of the entry used. On a write it also sets the written bit. Software loads and examines both tables through a simple word-addressed register port.

Top module: `page_xlate`

## Requirements
- R1: While `rstN` is low, every output register clears to zero, and every page-table word and space slot clears to zero.
- R2: A mapped access (`mapOn`=1, slot not transparent) with no violation produces, one clock after the access, `physAddr` = {entry[10:0], virtual[9:0]}. `legacyStb` is 1 if entry bit 11 is set; otherwise `fastStb` is 1. Never are both strobes 1.
- R3: The space slot index is {`accIspace`, `accMode`}. Slot bits 9:8 pick the page table. The table word address is {table, virtual[15:10]}. Slots whose mode field is 2'b10 hold no state: writes to them are ignored and they read as zero, so they act as table 0 with page limit 0.
- R4: If `mapOn` is 1 and virtual[15:10] exceeds the slot's page limit (slot bits 6:1), the access aborts with `abortCause` bit 2 set. This holds even when the slot is transparent.
- R5: On a mapped access, a read aborts with cause bit 1 if entry bit 12 (read permit) is clear. A write or read-modify-write read aborts with cause bit 0 if entry bit 13 (write permit) is clear. A read-modify-write read needs no read permit.
- R6: When `mapOn` is 0, or the slot's bit 7 (transparent) is set, the access bypasses translation. `physAddr`[15:0] equals the virtual address, and bits 17:16 are both 1 exactly when virtual[15:13] are all 1. The access goes to the legacy bus, and no permission check is made.
- R7: A mapped access that does not abort and has `accInternal`=0 sets bit 14 (accessed) of the entry used. It also sets bit 15 (written) if `accWrite`=1. Existing bits are kept. Bypassed, aborted or internal accesses change nothing.
- R8: For a legacy target, `legacyAddr` equals `physAddr`[17:0]. For a fast target, `legacyAddr`[17:16] is zero.
- R9: An abort suppresses both strobes. A cycle without `accValid` gives no strobe and no abort one clock later.
- R10: A config write with `cfgSpaceSel`=0 stores `cfgWdata` into page-table word `cfgAddr`. With `cfgSpaceSel`=1 it stores bits 9:1 into slot `cfgAddr`[2:0]. Each write is visible on `cfgRdata` on the next clock. A space slot reads back with bits 9:1 and zeros elsewhere. Writing zeros clears the status bits. A config write beats a same-cycle status update of the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mapOn | input | 1 | Global translation enable |
| accValid | input | 1 | Access strobe |
| accMode | input | 2 | Processor mode (00, 01, 11 meaningful) |
| accIspace | input | 1 | 1 = instruction space, 0 = data space |
| accWrite | input | 1 | Write access |
| accRmw | input | 1 | Read of a read-modify-write |
| accInternal | input | 1 | Access targets an internal register (no status update) |
| accAddr | input | 16 | Virtual address |
| cfgWrite | input | 1 | Table write strobe |
| cfgSpaceSel | input | 1 | 1 = space table, 0 = page tables |
| cfgAddr | input | 8 | Table word address |
| cfgWdata | input | 16 | Table write data |
| cfgRdata | output | 16 | Table read data for `cfgAddr` |
| physAddr | output | 21 | Registered physical address |
| legacyAddr | output | 18 | Registered legacy-bus address |
| legacyStb | output | 1 | Legacy-bus cycle request |
| fastStb | output | 1 | Fast-memory cycle request |
| abortReq | output | 1 | Access aborted |
| abortCause | output | 3 | {page limit, read permit, write permit} violation |

## Verification
The assertions assume the access inputs are steady for the whole cycle in which `accValid` is high. They also assume `accWrite` and `accRmw` are never both high, so that the registered outputs always reflect a single well-formed request. The bench drives every input at the falling edge and raises at most one of the two write flags per access. It loads the tables before the first access, and it changes `mapOn` only while `accValid` is low.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  localparam int VaW      = 16;
  localparam int OffW     = 10;
  localparam int PpnW     = 11;
  localparam int VpnW     = VaW - OffW;
  localparam int PaW      = PpnW + OffW;
  localparam int TabSelW  = 2;
  localparam int PtAddrW  = TabSelW + VpnW;
  localparam int PtWords  = 1 << PtAddrW;
  localparam int LegW     = 18;
  localparam int SlotW    = 3;
  localparam int NumSlots = 1 << SlotW;
  localparam int WordW    = 16;

  // entry bit positions decoded by the control path
  localparam int WrittenBit = 15;
  localparam int AccBit     = 14;
  localparam int WpBit      = 13;
  localparam int RpBit      = 12;
  localparam int LegBit     = 11;

  localparam logic [1:0] NoStateMode = 2'b10;

  typedef struct packed {
    logic [TabSelW-1:0] tab;
    logic               trans;
    logic [VpnW-1:0]    maxPg;
  } spaceDesc_t;

  typedef struct packed {
    logic ptWe;
    logic spWe;
    logic statUpd;
    logic setWr;
    logic bypass;
    logic useLegacy;
  } ctrlStb_t;
endpackage

// File: rtl/page_xlate_ctrl.sv
module page_xlate_ctrl
  import page_xlate_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            mapOn,
  input  logic            accValid,
  input  logic            accWrite,
  input  logic            accRmw,
  input  logic            accInternal,
  input  logic [VpnW-1:0] accVpn,
  input  spaceDesc_t      desc,
  input  logic [2:0]      entryFlags,   // {write permit, read permit, legacy}
  input  logic            cfgWrite,
  input  logic            cfgSpaceSel,
  input  logic [1:0]      cfgModeBits,
  output ctrlStb_t        stb,
  output logic            abortReq,
  output logic [2:0]      abortCause,
  output logic            legacyStb,
  output logic            fastStb
);
  logic bypass, needWr, maxViol, rdViol, wrViol, abortNow, useLegacy;
  logic [2:0] causeNow;

  always_comb begin
    bypass    = !mapOn || desc.trans;
    needWr    = accWrite || accRmw;
    maxViol   = mapOn && (accVpn > desc.maxPg);
    rdViol    = !bypass && !needWr && !entryFlags[1];
    wrViol    = !bypass && needWr && !entryFlags[2];
    causeNow  = {maxViol, rdViol, wrViol};
    abortNow  = accValid && (|causeNow);
    useLegacy = bypass || entryFlags[0];

    stb.bypass    = bypass;
    stb.useLegacy = useLegacy;
    stb.statUpd   = accValid && !bypass && !abortNow && !accInternal;
    stb.setWr     = accWrite;
    stb.ptWe      = cfgWrite && !cfgSpaceSel;
    stb.spWe      = cfgWrite && cfgSpaceSel && (cfgModeBits != NoStateMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abortReq   <= 1'b0;
      abortCause <= '0;
      legacyStb  <= 1'b0;
      fastStb    <= 1'b0;
    end else begin
      abortReq   <= abortNow;
      abortCause <= accValid ? causeNow : 3'b000;
      legacyStb  <= accValid && !abortNow && useLegacy;
      fastStb    <= accValid && !abortNow && !useLegacy;
    end
  end
endmodule

// File: rtl/page_xlate_dp.sv
module page_xlate_dp
  import page_xlate_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         accMode,
  input  logic               accIspace,
  input  logic [VaW-1:0]     accAddr,
  input  logic [PtAddrW-1:0] cfgAddr,
  input  logic               cfgSpaceSel,
  input  logic [WordW-1:0]   cfgWdata,
  input  ctrlStb_t           stb,
  output spaceDesc_t         desc,
  output logic [2:0]         entryFlags,
  output logic [WordW-1:0]   cfgRdata,
  output logic [PaW-1:0]     physAddr,
  output logic [LegW-1:0]    legacyAddr
);
  logic [WordW-1:0] ptMem [PtWords];
  spaceDesc_t       spMem [NumSlots];

  logic [SlotW-1:0]   slot;
  logic [PtAddrW-1:0] ptIdx;
  logic [WordW-1:0]   entry;
  logic [1:0]         devHi;
  logic [PaW-1:0]     nextPa;
  logic [LegW-1:0]    nextLeg;
  spaceDesc_t         cfgDesc;

  always_comb begin
    slot       = {accIspace, accMode};
    desc       = spMem[slot];
    ptIdx      = {desc.tab, accAddr[VaW-1:OffW]};
    entry      = ptMem[ptIdx];
    entryFlags = {entry[WpBit], entry[RpBit], entry[LegBit]};
    devHi      = {2{&accAddr[VaW-1:VaW-3]}};
    if (stb.bypass)
      nextPa = {{(PaW-LegW){1'b0}}, devHi, accAddr};
    else
      nextPa = {entry[PpnW-1:0], accAddr[OffW-1:0]};
    nextLeg = stb.useLegacy ? nextPa[LegW-1:0] : {2'b00, nextPa[LegW-3:0]};
    cfgDesc = spMem[cfgAddr[SlotW-1:0]];
    cfgRdata = cfgSpaceSel ? {{(WordW-$bits(spaceDesc_t)-1){1'b0}}, cfgDesc, 1'b0}
                           : ptMem[cfgAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PtWords; i++) ptMem[i] <= '0;
      for (int s = 0; s < NumSlots; s++) spMem[s] <= '0;
      physAddr   <= '0;
      legacyAddr <= '0;
    end else begin
      physAddr   <= nextPa;
      legacyAddr <= nextLeg;
      if (stb.statUpd) begin
        ptMem[ptIdx][AccBit] <= 1'b1;
        if (stb.setWr) ptMem[ptIdx][WrittenBit] <= 1'b1;
      end
      // software write comes last so it wins over a same-word status update
      if (stb.ptWe) ptMem[cfgAddr] <= cfgWdata;
      if (stb.spWe) spMem[cfgAddr[SlotW-1:0]] <= cfgWdata[$bits(spaceDesc_t):1];
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mapOn,
  input  logic        accValid,
  input  logic [1:0]  accMode,
  input  logic        accIspace,
  input  logic        accWrite,
  input  logic        accRmw,
  input  logic        accInternal,
  input  logic [15:0] accAddr,
  input  logic        cfgWrite,
  input  logic        cfgSpaceSel,
  input  logic [7:0]  cfgAddr,
  input  logic [15:0] cfgWdata,
  output logic [15:0] cfgRdata,
  output logic [20:0] physAddr,
  output logic [17:0] legacyAddr,
  output logic        legacyStb,
  output logic        fastStb,
  output logic        abortReq,
  output logic [2:0]  abortCause
);
  ctrlStb_t   stb;
  spaceDesc_t desc;
  logic [2:0] entryFlags;

  page_xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mapOn(mapOn), .accValid(accValid),
    .accWrite(accWrite), .accRmw(accRmw), .accInternal(accInternal),
    .accVpn(accAddr[VaW-1:OffW]), .desc(desc), .entryFlags(entryFlags),
    .cfgWrite(cfgWrite), .cfgSpaceSel(cfgSpaceSel), .cfgModeBits(cfgAddr[1:0]),
    .stb(stb), .abortReq(abortReq), .abortCause(abortCause),
    .legacyStb(legacyStb), .fastStb(fastStb)
  );

  page_xlate_dp u_dp (
    .clk(clk), .rstN(rstN), .accMode(accMode), .accIspace(accIspace),
    .accAddr(accAddr), .cfgAddr(cfgAddr), .cfgSpaceSel(cfgSpaceSel),
    .cfgWdata(cfgWdata), .stb(stb), .desc(desc), .entryFlags(entryFlags),
    .cfgRdata(cfgRdata), .physAddr(physAddr), .legacyAddr(legacyAddr)
  );
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mapOn,
  input logic        accValid,
  input logic [15:0] accAddr,
  input logic [20:0] physAddr,
  input logic [17:0] legacyAddr,
  input logic        legacyStb,
  input logic        fastStb,
  input logic        abortReq
);
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rstN)
    !(legacyStb && fastStb));

  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> (!legacyStb && !fastStb));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (!abortReq && !legacyStb && !fastStb));

  a_r8_fast_hides_regs: assert property (@(posedge clk) disable iff (!rstN)
    fastStb |-> (legacyAddr[17:16] == 2'b00));

  a_r8_legacy_copy: assert property (@(posedge clk) disable iff (!rstN)
    legacyStb |-> (legacyAddr == physAddr[17:0]));

  a_r6_unmapped_pass: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !mapOn) |=> (physAddr[15:0] == $past(accAddr) && !fastStb && !abortReq));
endmodule

bind page_xlate page_xlate_chk u_chk (.*);

// File: tb/page_xlate_test.sv
module page_xlate_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mapOn = 1'b1;
  logic        accValid = 1'b0;
  logic [1:0]  accMode = '0;
  logic        accIspace = 1'b0;
  logic        accWrite = 1'b0;
  logic        accRmw = 1'b0;
  logic        accInternal = 1'b0;
  logic [15:0] accAddr = '0;
  logic        cfgWrite = 1'b0;
  logic        cfgSpaceSel = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic [20:0] physAddr;
  logic [17:0] legacyAddr;
  logic        legacyStb, fastStb, abortReq;
  logic [2:0]  abortCause;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  page_xlate uut (.*);

  // {mapOn, mode, isp, wr, rmw, addr, abort, cause, phys, legacy, fast}
  localparam int NV = 15;
  localparam logic [48:0] VECS [NV] = '{
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0010, 1'b0, 3'b000, 21'h048C10, 1'b0, 1'b1},
    {1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 16'h0010, 1'b0, 3'b000, 21'h048C10, 1'b0, 1'b1},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0404, 1'b0, 3'b000, 21'h001404, 1'b1, 1'b0},
    {1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 16'h0404, 1'b1, 3'b001, 21'h000000, 1'b0, 1'b0},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0800, 1'b1, 3'b010, 21'h000000, 1'b0, 1'b0},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 16'h0800, 1'b0, 3'b000, 21'h1FFC00, 1'b0, 1'b1},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0C00, 1'b1, 3'b010, 21'h000000, 1'b0, 1'b0},
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0020, 1'b0, 3'b000, 21'h100020, 1'b0, 1'b1},
    {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 16'h0800, 1'b0, 3'b000, 21'h030400, 1'b1, 1'b0},
    {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 16'h1000, 1'b1, 3'b110, 21'h000000, 1'b0, 1'b0},
    {1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 16'hE123, 1'b0, 3'b000, 21'h03E123, 1'b1, 1'b0},
    {1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 16'h1C00, 1'b0, 3'b000, 21'h001C00, 1'b1, 1'b0},
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 16'h2000, 1'b1, 3'b100, 21'h000000, 1'b0, 1'b0},
    {1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 16'hF000, 1'b0, 3'b000, 21'h03F000, 1'b1, 1'b0},
    {1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0404, 1'b1, 3'b100, 21'h000000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfgWr(input logic sel, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWrite = 1'b1; cfgSpaceSel = sel; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic cfgRd(input string req, input logic sel, input logic [7:0] a,
                       input logic [15:0] exp);
    @(negedge clk);
    cfgSpaceSel = sel; cfgAddr = a;
    #1;
    chk(req, {16'h0, cfgRdata}, {16'h0, exp});
  endtask

  task automatic access(input logic m, input logic [1:0] md, input logic isp,
                        input logic wr, input logic rmw, input logic intl,
                        input logic [15:0] a);
    @(negedge clk);
    mapOn = m; accMode = md; accIspace = isp; accWrite = wr; accRmw = rmw;
    accInternal = intl; accAddr = a; accValid = 1'b1;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 abort", {31'h0, abortReq}, 32'h0);
    chk("R1 strobes", {30'h0, legacyStb, fastStb}, 32'h0);
    chk("R1 phys", {11'h0, physAddr}, 32'h0);
    rstN = 1'b1;
    cfgRd("R1 table clear", 1'b0, 8'h00, 16'h0000);

    // space slots: {isp, mode}
    cfgWr(1'b1, 8'h00, 16'h007E);   // kernel D: table 0, limit 63
    cfgWr(1'b1, 8'h04, 16'h017E);   // kernel I: table 1, limit 63
    cfgWr(1'b1, 8'h03, 16'h0206);   // user D: table 2, limit 3
    cfgWr(1'b1, 8'h07, 16'h03FE);   // user I: transparent, limit 63
    cfgWr(1'b1, 8'h01, 16'h008E);   // super D: transparent, limit 7
    cfgWr(1'b1, 8'h02, 16'h00FE);   // no-state slot, ignored
    cfgWr(1'b0, 8'h00, 16'h3123);
    cfgWr(1'b0, 8'h01, 16'h1805);
    cfgWr(1'b0, 8'h02, 16'h27FF);
    cfgWr(1'b0, 8'h40, 16'h1400);
    cfgWr(1'b0, 8'h82, 16'h38C1);
    cfgRd("R10 space readback", 1'b1, 8'h03, 16'h0206);
    cfgRd("R3 no-state slot reads zero", 1'b1, 8'h02, 16'h0000);
    cfgRd("R10 page readback", 1'b0, 8'h01, 16'h1805);

    // vector table: R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VECS[i];
      access(v[48], v[47:46], v[45], v[44], v[43], 1'b0, v[42:27]);
      chk("R4 R5 R9 abort", {31'h0, abortReq}, {31'h0, v[26]});
      chk("R4 R5 cause", {29'h0, abortCause}, {29'h0, v[25:23]});
      chk("R2 R9 strobes", {30'h0, legacyStb, fastStb}, {30'h0, v[1], v[0]});
      if (!v[26]) begin
        chk("R2 R3 R6 phys", {11'h0, physAddr}, {11'h0, v[22:2]});
        chk("R8 legacy addr", {14'h0, legacyAddr},
            {14'h0, (v[1] ? v[19:2] : {2'b00, v[17:2]})});
      end
    end
    mapOn = 1'b1;

    // R7 status bits
    cfgRd("R7 read+write sets both", 1'b0, 8'h00, 16'hF123);
    cfgRd("R7 aborted write keeps written clear", 1'b0, 8'h01, 16'h5805);
    cfgRd("R7 rmw read marks accessed only", 1'b0, 8'h02, 16'h67FF);
    cfgRd("R7 other table", 1'b0, 8'h40, 16'h5400);
    cfgRd("R7 legacy entry", 1'b0, 8'h82, 16'h78C1);
    cfgRd("R7 transparent no update", 1'b0, 8'h07, 16'h0000);
    cfgRd("R7 aborted entry untouched", 1'b0, 8'h03, 16'h0000);

    // R10 clearing by software, then R7 internal access ignored
    cfgWr(1'b0, 8'h82, 16'h38C1);
    cfgRd("R10 zeros clear status", 1'b0, 8'h82, 16'h38C1);
    access(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0800);
    chk("R7 internal still translates", {31'h0, legacyStb}, 32'h1);
    cfgRd("R7 internal access no update", 1'b0, 8'h82, 16'h38C1);
    access(1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0800);
    cfgRd("R7 write sets written", 1'b0, 8'h82, 16'hF8C1);

    // R10 config write beats same-cycle status update
    cfgWr(1'b0, 8'h82, 16'h38C1);
    @(negedge clk);
    accMode = 2'd3; accIspace = 1'b0; accWrite = 1'b1; accRmw = 1'b0;
    accInternal = 1'b0; accAddr = 16'h0800; accValid = 1'b1;
    cfgWrite = 1'b1; cfgSpaceSel = 1'b0; cfgAddr = 8'h82; cfgWdata = 16'h38C1;
    @(negedge clk);
    accValid = 1'b0; cfgWrite = 1'b0; accWrite = 1'b0;
    cfgRd("R10 software write wins", 1'b0, 8'h82, 16'h38C1);

    // R9 idle cycle
    @(negedge clk);
    chk("R9 idle no strobe", {29'h0, legacyStb, fastStb, abortReq}, 32'h0);

    // R1 mid-run reset
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R1 reset clears tables", {16'h0, cfgRdata}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    cfgRd("R1 reset clears space", 1'b1, 8'h03, 16'h0000);

    finishRun();
  end
endmodule